// File: doc/BRIEF.md
# Fixed-Priority Mesh Router Node

This block is the switch at one node of a two-dimensional mesh of processing elements that exchange pixel packets. It has four neighbour channels (North, South, East, West) and one channel to the local processor. Each channel carries a valid bit and a packet that holds a pixel value, a destination node coordinate and a frame (argument) number. The node's own coordinate is fixed by parameters.

Packets from the processor go through a de-multiplexer. It picks the outgoing neighbour channel from the destination coordinate using dimension order: X is corrected first, then Y. A packet whose destination equals this node is looped back to the processor. Packets that arrive from neighbours go through a multiplexer toward the processor, together with any looped-back packet. The multiplexer passes one packet per cycle, chosen by fixed port priority.

The node has no buffers and no flow control. Whenever a simultaneous arrival forces a choice, the packets that lose are discarded and a one-cycle collision flag is raised. Every output is registered, so each hop costs one clock cycle.

Top module: `mesh_router_node`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `nb_out_vld`, `nb_out_pkt`, `pe_rx_vld`, `pe_rx_pkt` and `collide` are all zero, even if inputs are active during reset.
- R2: A packet is PKT_W = PIX_W + 2*COORD_W + ARG_W bits wide. The pixel sits in bits [PIX_W-1:0], destination X in the next COORD_W bits, destination Y in the next COORD_W bits, and the argument number in the top ARG_W bits. With the defaults (8, 3, 2) this gives pixel [7:0], X [10:8], Y [13:11] and argument [15:14]. A routed packet leaves bit-for-bit unchanged.
- R3: Neighbour lanes are indexed 0 = North, 1 = South, 2 = East, 3 = West. Lane i of `nb_in_pkt`/`nb_out_pkt` occupies bits [i*PKT_W +: PKT_W]. A processor packet whose destination X is greater than NODE_X appears on lane 2 (East) one cycle later.
- R4: A processor packet whose destination X is less than NODE_X appears on lane 3 (West) one cycle later.
- R5: A processor packet whose destination X equals NODE_X goes to lane 0 (North) one cycle later if its destination Y is less than NODE_Y, and to lane 1 (South) if it is greater.
- R6: A processor packet whose destination equals (NODE_X, NODE_Y) drives no neighbour lane. It is delivered on `pe_rx_pkt` one cycle later as the lowest-priority contender.
- R7: A single packet arriving on one neighbour lane is delivered on `pe_rx_pkt` with `pe_rx_vld` high one cycle later, and `collide` stays low.
- R8: When several contenders arrive together, the one passed to the processor is chosen in the fixed order North, South, East, West, then local loopback.
- R9: `collide` is high for exactly the cycle after two or more contenders arrive together. The losing packets are discarded: they are not delivered in that cycle or in any later cycle.
- R10: At most one `nb_out_vld` bit is high in any cycle. Lanes that are not valid carry all-zero data. With no valid input at all, every output is zero in the next cycle.
- R11: An outgoing processor packet to a neighbour and an incoming neighbour packet in the same cycle are both carried out in the next cycle, without a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nb_in_vld | input | 4 | Valid per incoming neighbour lane (N, S, E, W) |
| nb_in_pkt | input | 4*PKT_W | Packets arriving from neighbours, lane i at [i*PKT_W +: PKT_W] |
| pe_tx_vld | input | 1 | Processor has a packet to send |
| pe_tx_pkt | input | PKT_W | Packet from the processor |
| nb_out_vld | output | 4 | Registered valid per outgoing neighbour lane |
| nb_out_pkt | output | 4*PKT_W | Registered outgoing packets, zero on idle lanes |
| pe_rx_vld | output | 1 | Registered valid toward the processor |
| pe_rx_pkt | output | PKT_W | Registered packet toward the processor |
| collide | output | 1 | Registered flag: packets were dropped in the previous cycle |

## Verification
Two functions can fall in the same cycle. One is the outgoing route decode of a processor packet; the other is the priority selection among arrivals headed for the processor, which a local loopback packet also enters. The bench drives a processor packet bound for a neighbour together with an arrival, and checks that both come out unchanged and that no collision is flagged. It also drives a loopback packet together with a neighbour arrival, and checks that the neighbour wins, the flag rises and the loopback packet never appears. Grouped arrivals on several lanes are judged on the chosen winner, on the flag, and on an idle following cycle that shows the losers were really discarded.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

  localparam int NB_LANES = 4;
  localparam int CONTENDERS = NB_LANES + 1;

  typedef enum logic [2:0] {
    LANE_N     = 3'd0,
    LANE_S     = 3'd1,
    LANE_E     = 3'd2,
    LANE_W     = 3'd3,
    LANE_LOCAL = 3'd4
  } lane_e;

endpackage

// File: rtl/xy_route_decode.sv
module xy_route_decode
  import mesh_rt_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int NODE_X  = 3,
  parameter int NODE_Y  = 3
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output lane_e              lane
);

  localparam logic [COORD_W-1:0] HX = COORD_W'(NODE_X);
  localparam logic [COORD_W-1:0] HY = COORD_W'(NODE_Y);

  always_comb begin
    if (dst_x > HX)      lane = LANE_E;
    else if (dst_x < HX) lane = LANE_W;
    else if (dst_y < HY) lane = LANE_N;
    else if (dst_y > HY) lane = LANE_S;
    else                 lane = LANE_LOCAL;
  end

endmodule

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
  parameter int N   = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          multi
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end

  assign multi = |(req & ~grant);

endmodule

// File: rtl/mesh_router_node.sv
module mesh_router_node
  import mesh_rt_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 3,
  parameter int ARG_W   = 2,
  parameter int NODE_X  = 3,
  parameter int NODE_Y  = 3,
  localparam int PKT_W  = PIX_W + 2 * COORD_W + ARG_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NB_LANES-1:0]        nb_in_vld,
  input  logic [NB_LANES*PKT_W-1:0]  nb_in_pkt,
  input  logic                       pe_tx_vld,
  input  logic [PKT_W-1:0]           pe_tx_pkt,
  output logic [NB_LANES-1:0]        nb_out_vld,
  output logic [NB_LANES*PKT_W-1:0]  nb_out_pkt,
  output logic                       pe_rx_vld,
  output logic [PKT_W-1:0]           pe_rx_pkt,
  output logic                       collide
);

  localparam int XLO = PIX_W;
  localparam int YLO = PIX_W + COORD_W;
  localparam int CW  = $clog2(CONTENDERS);

  // Outgoing de-multiplexer
  lane_e tx_lane;

  xy_route_decode #(
    .COORD_W(COORD_W),
    .NODE_X (NODE_X),
    .NODE_Y (NODE_Y)
  ) dec_i (
    .dst_x(pe_tx_pkt[XLO +: COORD_W]),
    .dst_y(pe_tx_pkt[YLO +: COORD_W]),
    .lane (tx_lane)
  );

  logic [NB_LANES-1:0]       out_vld_d;
  logic [NB_LANES*PKT_W-1:0] out_pkt_d;

  for (genvar l = 0; l < NB_LANES; l++) begin : g_demux
    assign out_vld_d[l]             = pe_tx_vld && (tx_lane == lane_e'(l));
    assign out_pkt_d[l*PKT_W +: PKT_W] = out_vld_d[l] ? pe_tx_pkt : '0;
  end

  // Incoming multiplexer (neighbours first, loopback last)
  logic [CONTENDERS-1:0] req;
  logic [CONTENDERS-1:0] grant;
  logic [CW-1:0]         win_idx;
  logic                  multi;
  logic [PKT_W-1:0]      cand [CONTENDERS];
  logic [PKT_W-1:0]      win_pkt;

  assign req = {pe_tx_vld && (tx_lane == LANE_LOCAL), nb_in_vld};

  for (genvar c = 0; c < NB_LANES; c++) begin : g_cand
    assign cand[c] = nb_in_pkt[c*PKT_W +: PKT_W];
  end
  assign cand[NB_LANES] = pe_tx_pkt;

  fixed_prio_pick #(.N(CONTENDERS)) pick_i (
    .req  (req),
    .grant(grant),
    .idx  (win_idx),
    .multi(multi)
  );

  always_comb begin
    win_pkt = '0;
    for (int c = 0; c < CONTENDERS; c++) begin
      if (win_idx == CW'(c) && |grant) win_pkt = cand[c];
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      nb_out_vld <= '0;
      nb_out_pkt <= '0;
      pe_rx_vld  <= 1'b0;
      pe_rx_pkt  <= '0;
      collide    <= 1'b0;
    end else begin
      nb_out_vld <= out_vld_d;
      nb_out_pkt <= out_pkt_d;
      pe_rx_vld  <= |grant;
      pe_rx_pkt  <= win_pkt;
      collide    <= multi;
    end
  end

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 3,
  parameter int ARG_W   = 2,
  parameter int NODE_X  = 3,
  parameter int NODE_Y  = 3,
  localparam int PKT_W  = PIX_W + 2 * COORD_W + ARG_W
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         nb_in_vld,
  input logic               pe_tx_vld,
  input logic [PKT_W-1:0]   pe_tx_pkt,
  input logic [3:0]         nb_out_vld,
  input logic               pe_rx_vld,
  input logic               collide
);

  localparam logic [COORD_W-1:0] HX = COORD_W'(NODE_X);

  logic [COORD_W-1:0] tx_x;
  assign tx_x = pe_tx_pkt[PIX_W +: COORD_W];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (nb_out_vld == 4'b0 && !pe_rx_vld && !collide));

  // R10
  one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nb_out_vld));

  // R3
  east_route_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_tx_vld && tx_x > HX) |=> nb_out_vld == 4'b0100);

  // R4
  west_route_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_tx_vld && tx_x < HX) |=> nb_out_vld == 4'b1000);

  // R7
  arrival_delivered_chk: assert property (@(posedge clk) disable iff (rst)
    (|nb_in_vld) |=> pe_rx_vld);

  // R9
  collide_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(nb_in_vld) >= 2) |=> collide);

  // R9
  collide_has_winner_chk: assert property (@(posedge clk) disable iff (rst)
    collide |-> pe_rx_vld);

endmodule

bind mesh_router_node mesh_router_chk #(
  .PIX_W  (PIX_W),
  .COORD_W(COORD_W),
  .ARG_W  (ARG_W),
  .NODE_X (NODE_X),
  .NODE_Y (NODE_Y)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .nb_in_vld (nb_in_vld),
  .pe_tx_vld (pe_tx_vld),
  .pe_tx_pkt (pe_tx_pkt),
  .nb_out_vld(nb_out_vld),
  .pe_rx_vld (pe_rx_vld),
  .collide   (collide)
);

// File: tb/mesh_router_node_tb_top.sv
module mesh_router_node_tb_top;

  localparam int PKT_W = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [3:0]          nb_in_vld = '0;
  logic [4*PKT_W-1:0]  nb_in_pkt = '0;
  logic                pe_tx_vld = 1'b0;
  logic [PKT_W-1:0]    pe_tx_pkt = '0;
  logic [3:0]          nb_out_vld;
  logic [4*PKT_W-1:0]  nb_out_pkt;
  logic                pe_rx_vld;
  logic [PKT_W-1:0]    pe_rx_pkt;
  logic                collide;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mesh_router_node dut_i (
    .clk(clk), .rst(rst),
    .nb_in_vld(nb_in_vld), .nb_in_pkt(nb_in_pkt),
    .pe_tx_vld(pe_tx_vld), .pe_tx_pkt(pe_tx_pkt),
    .nb_out_vld(nb_out_vld), .nb_out_pkt(nb_out_pkt),
    .pe_rx_vld(pe_rx_vld), .pe_rx_pkt(pe_rx_pkt),
    .collide(collide)
  );

  // R2 layout: {arg[15:14], y[13:11], x[10:8], pixel[7:0]}
  function automatic logic [15:0] mk(input int arg, input int y, input int x, input int pix);
    return {2'(arg), 3'(y), 3'(x), 8'(pix)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    nb_in_vld = '0; nb_in_pkt = '0; pe_tx_vld = 1'b0; pe_tx_pkt = '0;
  endtask

  // inputs driven at negedge, captured at next posedge, checked at following negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    pe_tx_vld = 1'b1; pe_tx_pkt = mk(1, 3, 6, 8'h11);
    nb_in_vld = 4'b0011; nb_in_pkt = {32'h0, 16'h1234, 16'h5678};
    repeat (3) step();
    chk("R1 nb_out_vld", 64'(nb_out_vld), 64'h0);
    chk("R1 nb_out_pkt", nb_out_pkt, 64'h0);
    chk("R1 pe_rx_vld", 64'(pe_rx_vld), 64'h0);
    chk("R1 collide", 64'(collide), 64'h0);
    idle_inputs();
    rst = 1'b0;
    step();
  endtask

  task automatic t_route(input string req, input int x, input int y, input int lane, input int pix);
    logic [15:0] p;
    logic [63:0] exp_pkt;
    p = mk(2, y, x, pix);
    pe_tx_vld = 1'b1; pe_tx_pkt = p;
    step();
    idle_inputs();
    exp_pkt = '0;
    exp_pkt[lane*16 +: 16] = p;
    chk({req, " lane valid"}, 64'(nb_out_vld), 64'(4'b1 << lane));
    chk({req, " R2 packet unchanged / R10 idle lanes zero"}, nb_out_pkt, exp_pkt);
    chk({req, " no delivery"}, 64'(pe_rx_vld), 64'h0);
  endtask

  task automatic t_local();
    logic [15:0] p;
    p = mk(3, 3, 3, 8'hA5);
    pe_tx_vld = 1'b1; pe_tx_pkt = p;
    step();
    idle_inputs();
    chk("R6 no neighbour lane", 64'(nb_out_vld), 64'h0);
    chk("R6 loopback valid", 64'(pe_rx_vld), 64'h1);
    chk("R6 loopback packet", 64'(pe_rx_pkt), 64'(p));
  endtask

  task automatic t_single(input int lane);
    logic [15:0] p;
    p = mk(1, lane, 7 - lane, 8'h30 + lane);
    nb_in_vld = 4'b1 << lane;
    nb_in_pkt = '0; nb_in_pkt[lane*16 +: 16] = p;
    step();
    idle_inputs();
    chk("R7 single valid", 64'(pe_rx_vld), 64'h1);
    chk("R7 single packet", 64'(pe_rx_pkt), 64'(p));
    chk("R7 no collide", 64'(collide), 64'h0);
  endtask

  task automatic t_collide(input logic [3:0] vld, input bit loop, input int win);
    logic [15:0] p [5];
    for (int i = 0; i < 4; i++) p[i] = mk(i, i, i + 1, 8'hC0 + i);
    p[4] = mk(0, 3, 3, 8'hEE);
    nb_in_vld = vld;
    for (int i = 0; i < 4; i++) nb_in_pkt[i*16 +: 16] = p[i];
    pe_tx_vld = loop; pe_tx_pkt = p[4];
    step();
    idle_inputs();
    chk("R8 winner valid", 64'(pe_rx_vld), 64'h1);
    chk("R8 winner packet", 64'(pe_rx_pkt), 64'(p[win]));
    chk("R9 collide flag", 64'(collide), 64'h1);
    chk("R9 losers not routed out", 64'(nb_out_vld), 64'h0);
    step();
    chk("R9 losers not delivered later", 64'(pe_rx_vld), 64'h0);
    chk("R9 collide one cycle", 64'(collide), 64'h0);
  endtask

  task automatic t_concurrent();
    logic [15:0] o, n;
    o = mk(1, 5, 3, 8'h77);
    n = mk(2, 3, 3, 8'h99);
    pe_tx_vld = 1'b1; pe_tx_pkt = o;
    nb_in_vld = 4'b0010; nb_in_pkt = '0; nb_in_pkt[16 +: 16] = n;
    step();
    idle_inputs();
    chk("R11 outgoing south", 64'(nb_out_vld), 64'h2);
    chk("R11 outgoing packet", 64'(nb_out_pkt[16 +: 16]), 64'(o));
    chk("R11 incoming packet", 64'(pe_rx_pkt), 64'(n));
    chk("R11 no collide", 64'(collide), 64'h0);
  endtask

  task automatic t_idle();
    step();
    chk("R10 idle lanes", 64'(nb_out_vld), 64'h0);
    chk("R10 idle data", nb_out_pkt, 64'h0);
    chk("R10 idle rx", 64'(pe_rx_vld), 64'h0);
  endtask

  initial begin
    step();
    t_reset();
    t_route("R3 east", 6, 0, 2, 8'h21);
    t_route("R3 east near", 4, 3, 2, 8'h22);
    t_route("R4 west", 0, 7, 3, 8'h23);
    t_route("R5 north", 3, 1, 0, 8'h24);
    t_route("R5 south", 3, 6, 1, 8'h25);
    t_local();
    for (int l = 0; l < 4; l++) t_single(l);
    t_collide(4'b1101, 1'b0, 0);
    t_collide(4'b1010, 1'b0, 1);
    t_collide(4'b1100, 1'b1, 2);
    t_collide(4'b1000, 1'b1, 3);
    t_concurrent();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule